// File: doc/BRIEF.md
# Cycle-Counting Timer Compare Interrupt

This block is the timer of a processor's system-control coprocessor. A free-running counter advances on every core clock edge, while software reads and writes it in coarser units: one visible tick spans `2**DIV_LOG2` core cycles, which is two by default. The counter is wider than the software view by `DIV_LOG2` bits. Writes are scaled up by a left shift and reads are scaled down by a right shift. A compare register holds a visible-resolution target. When the visible count equals the target, the block raises a timer interrupt-pending bit. Software acknowledges the interrupt by writing the compare register.

The pending bit is raised only once for each match, even though the counter stays on one visible value for several core cycles. It is also raised only on a cycle in which the core reports a retired instruction. A match that occurs between retirements is remembered and then delivered on the next retirement. Because of this rule, when a count write creates a match, the pending bit rises only after that write instruction has completed. The interrupt-enable masking and the exception entry that consume the pending bit sit outside this block.

Top module: `tick_cmp_timer`

## Requirements
- R1: The internal counter (VIS_W+DIV_LOG2 bits) increments by one on every clock edge without a count write. `cnt_rd_data` is the internal value shifted right by DIV_LOG2, so the visible count advances once every `2**DIV_LOG2` cycles (every 2 cycles by default).
- R2: A clock edge with `cnt_wr_en` high loads the internal counter with `wr_data` shifted left by DIV_LOG2 (low bits zero). On the following cycle `cnt_rd_data` equals `wr_data` and holds it for `2**DIV_LOG2` cycles.
- R3: The visible count wraps from all ones to zero, with no other side effect.
- R4: A clock edge with `cmp_wr_en` high loads the compare register from `wr_data` and leaves `irq_pend` low afterwards. This also discards any match that has not yet been delivered, and it takes priority over a match delivered on the same edge.
- R5: A match is the visible count equal to the compare value while the internal low DIV_LOG2 bits are zero. A visible value therefore yields at most one match, and the later cycles spent on the same value never set `irq_pend`.
- R6: `irq_pend` can rise only on an edge where `retire` is high. A match seen while `retire` is low is held and then delivered on the next edge with `retire` high. A match caused by a count write therefore appears only on a retirement after the write's own cycle.
- R7: Synchronous reset (`rst` high at an edge) clears the counter and `irq_pend`, discards any undelivered match, and sets the compare register to all ones.
- R8: Once set, `irq_pend` stays high until a compare write or reset, whatever the counter and `retire` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter advances on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_wr_en | input | 1 | Software write of the count register |
| cmp_wr_en | input | 1 | Software write of the compare register; also acknowledges the interrupt |
| wr_data | input | VIS_W | Data for either write, in visible units |
| retire | input | 1 | High in a cycle where the core retires an instruction |
| cnt_rd_data | output | VIS_W | Visible count (internal count shifted right) |
| irq_pend | output | 1 | Timer interrupt-pending bit |

## Verification
The bench builds the block with its defaults: VIS_W of 32 and DIV_LOG2 of 1. With these values, each visible value lasts exactly two cycles, so the second, non-matching cycle of a value can be reached directly. With a full 32-bit visible width, a write of all ones reaches the wrap within two cycles. The directed tests place count writes, compare writes and the `retire` strobe on exact cycles relative to a match. This exposes the once-per-value gate, the deferral of a match to the next retirement, and the priority of an acknowledge over a delivery.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Largest supported ratio exponent between core and visible rate.
   localparam int unsigned MAX_DIV_LOG2 = 4;
   localparam int unsigned MIN_VIS_W    = 8;

   // Internal counter width for a given visible width and ratio exponent.
   function automatic int unsigned int_width(input int unsigned vis_w,
                                             input int unsigned div_log2);
      return vis_w + div_log2;
   endfunction
endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
   parameter int unsigned VIS_W    = 32,
   parameter int unsigned DIV_LOG2 = 1,
   localparam int unsigned CNT_W   = tmr_pkg::int_width(VIS_W, DIV_LOG2)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [VIS_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] load_scaled;

   generate
      if (DIV_LOG2 == 0) begin : g_unit
         assign load_scaled = load_val;
      end else begin : g_scaled
         assign load_scaled = {load_val, {DIV_LOG2{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (load) cnt <= load_scaled;
      else           cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/tmr_hit_detect.sv
module tmr_hit_detect #(
   parameter int unsigned VIS_W    = 32,
   parameter int unsigned DIV_LOG2 = 1,
   localparam int unsigned CNT_W   = tmr_pkg::int_width(VIS_W, DIV_LOG2)
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [VIS_W-1:0] cmp,
   output logic             hit
);
   logic first_phase;
   logic vis_equal;

   assign vis_equal = (cnt[CNT_W-1:DIV_LOG2] == cmp);

   generate
      if (DIV_LOG2 == 0) begin : g_no_phase
         assign first_phase = 1'b1;
      end else begin : g_phase
         assign first_phase = (cnt[DIV_LOG2-1:0] == '0);
      end
   endgenerate

   assign hit = vis_equal & first_phase;
endmodule

// File: rtl/tmr_pend_ctl.sv
module tmr_pend_ctl (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   input  logic retire,
   input  logic ack,
   output logic pend
);
   logic armed;
   logic want;

   assign want = armed | hit;

   always_ff @(posedge clk) begin
      if (rst || ack) begin
         pend  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (retire && want) pend <= 1'b1;
         armed <= want & ~retire;
      end
   end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
   parameter int unsigned VIS_W    = 32,
   parameter int unsigned DIV_LOG2 = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_wr_en,
   input  logic             cmp_wr_en,
   input  logic [VIS_W-1:0] wr_data,
   input  logic             retire,
   output logic [VIS_W-1:0] cnt_rd_data,
   output logic             irq_pend
);
   localparam int unsigned CNT_W = tmr_pkg::int_width(VIS_W, DIV_LOG2);

   generate
      if (DIV_LOG2 > tmr_pkg::MAX_DIV_LOG2) begin : g_bad_div
         $error("tick_cmp_timer: DIV_LOG2 too large");
      end
      if (VIS_W < tmr_pkg::MIN_VIS_W) begin : g_bad_w
         $error("tick_cmp_timer: VIS_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [VIS_W-1:0] cmp_q;
   logic             hit;

   tmr_count_reg #(.VIS_W(VIS_W), .DIV_LOG2(DIV_LOG2)) u_count (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_wr_en),
      .load_val (wr_data),
      .cnt      (cnt_q)
   );

   always_ff @(posedge clk) begin
      if (rst)            cmp_q <= '1;
      else if (cmp_wr_en) cmp_q <= wr_data;
   end

   tmr_hit_detect #(.VIS_W(VIS_W), .DIV_LOG2(DIV_LOG2)) u_hit (
      .cnt (cnt_q),
      .cmp (cmp_q),
      .hit (hit)
   );

   tmr_pend_ctl u_pend (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit),
      .retire (retire),
      .ack    (cmp_wr_en),
      .pend   (irq_pend)
   );

   assign cnt_rd_data = cnt_q[CNT_W-1:DIV_LOG2];
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
   parameter int unsigned VIS_W    = 32,
   parameter int unsigned DIV_LOG2 = 1,
   localparam int unsigned CNT_W   = tmr_pkg::int_width(VIS_W, DIV_LOG2)
) (
   input logic             clk,
   input logic             rst,
   input logic             cnt_wr_en,
   input logic             cmp_wr_en,
   input logic [VIS_W-1:0] wr_data,
   input logic             retire,
   input logic [VIS_W-1:0] cnt_rd_data,
   input logic             irq_pend,
   input logic [CNT_W-1:0] cnt_q
);
   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      !cnt_wr_en |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      cnt_wr_en |=> cnt_rd_data == $past(wr_data));

   a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
      cmp_wr_en |=> !irq_pend);

   a_r6_rise_on_retire: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_pend) |-> $past(retire));

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      irq_pend && !cmp_wr_en |=> irq_pend);
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.VIS_W(VIS_W), .DIV_LOG2(DIV_LOG2)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cnt_wr_en   (cnt_wr_en),
   .cmp_wr_en   (cmp_wr_en),
   .wr_data     (wr_data),
   .retire      (retire),
   .cnt_rd_data (cnt_rd_data),
   .irq_pend    (irq_pend),
   .cnt_q       (cnt_q)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cnt_wr_en = 1'b0;
   logic        cmp_wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        retire = 1'b0;
   logic [31:0] cnt_rd_data;
   logic        irq_pend;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tick_cmp_timer u_tick_cmp_timer (
      .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cmp_wr_en(cmp_wr_en),
      .wr_data(wr_data), .retire(retire), .cnt_rd_data(cnt_rd_data),
      .irq_pend(irq_pend)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_cnt(input logic [31:0] v);
      cnt_wr_en = 1'b1; wr_data = v; tick(); cnt_wr_en = 1'b0;
   endtask

   task automatic wr_cmp(input logic [31:0] v);
      cmp_wr_en = 1'b1; wr_data = v; tick(); cmp_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1; retire = 1'b1; tick(3); rst = 1'b0;
      chk("R7 count after reset", cnt_rd_data, 32'd0);
      chk("R7 pend after reset", {31'd0, irq_pend}, 32'd0);
      tick(2); chk("R1 visible after 2 cycles", cnt_rd_data, 32'd1);
      tick(1); chk("R1 visible mid-tick", cnt_rd_data, 32'd1);
      tick(1); chk("R1 visible after 4 cycles", cnt_rd_data, 32'd2);
      tick(20);
      chk("R7 compare all ones, no match near zero", {31'd0, irq_pend}, 32'd0);
      retire = 1'b0;
   endtask

   task automatic t_count_write;
      wr_cnt(32'h1234_5678);
      chk("R2 read after write", cnt_rd_data, 32'h1234_5678);
      tick(); chk("R2 held second cycle", cnt_rd_data, 32'h1234_5678);
      tick(); chk("R2 then advances", cnt_rd_data, 32'h1234_5679);
   endtask

   task automatic t_wrap;
      wr_cnt(32'hFFFF_FFFF);
      chk("R3 all ones", cnt_rd_data, 32'hFFFF_FFFF);
      tick(2); chk("R3 wraps to zero", cnt_rd_data, 32'd0);
   endtask

   task automatic t_deferred;
      retire = 1'b0;
      wr_cmp(32'd100);
      wr_cnt(32'd99);
      tick(8);
      chk("R6 no pend without retire", {31'd0, irq_pend}, 32'd0);
      retire = 1'b1; tick(); retire = 1'b0;
      chk("R6 held match delivered on retire", {31'd0, irq_pend}, 32'd1);
      tick(10);
      chk("R8 pend holds", {31'd0, irq_pend}, 32'd1);
      wr_cmp(32'd5000);
      chk("R4 compare write clears", {31'd0, irq_pend}, 32'd0);
   endtask

   task automatic t_write_match;
      wr_cmp(32'd70);
      retire = 1'b1;
      wr_cnt(32'd70);
      retire = 1'b0;
      chk("R6 no pend in write's own retire", {31'd0, irq_pend}, 32'd0);
      tick(3);
      chk("R6 still waiting for later retire", {31'd0, irq_pend}, 32'd0);
      retire = 1'b1; tick(); retire = 1'b0;
      chk("R6 pend after later retire", {31'd0, irq_pend}, 32'd1);
   endtask

   task automatic t_once;
      wr_cmp(32'd50);
      retire = 1'b1;
      wr_cnt(32'd50);
      cmp_wr_en = 1'b1; wr_data = 32'd50; tick(); cmp_wr_en = 1'b0;
      chk("R4 ack wins over same-edge delivery", {31'd0, irq_pend}, 32'd0);
      tick();
      chk("R5 second cycle of value does not set", {31'd0, irq_pend}, 32'd0);
      tick(6);
      chk("R5 no later set", {31'd0, irq_pend}, 32'd0);
      retire = 1'b0;
   endtask

   task automatic t_reset_clears_pend;
      wr_cmp(32'd10);
      retire = 1'b1;
      wr_cnt(32'd10);
      tick();
      chk("R6 match with retire sets", {31'd0, irq_pend}, 32'd1);
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R7 reset clears pend", {31'd0, irq_pend}, 32'd0);
      chk("R7 reset clears count", cnt_rd_data, 32'd0);
      tick(4);
      chk("R7 compare back to all ones", {31'd0, irq_pend}, 32'd0);
      retire = 1'b0;
   endtask

   initial begin
      tick();
      t_reset();
      t_count_write();
      t_wrap();
      t_deferred();
      t_write_match();
      t_once();
      t_reset_clears_pend();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               checks++; errors++;
               $display("FAIL watchdog expired");
            end
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule